// File: doc/BRIEF.md
# SDRAM Refresh Scheduler with Deferred Refresh Debt

This block decides when the memory controller must send an AUTO REFRESH to the SDRAM. A free-running interval counter, sized from the configured clock period, fires once per average refresh interval of 7.8 µs. That interval covers 8192 rows in 64 ms. Each firing adds one owed refresh to a debt counter. The scheduler does not force the command arbiter to act at once. It asks for a refresh only while the arbiter reports idle, so refreshes can fall behind during busy traffic.

When the debt reaches its ceiling of eight, the request becomes urgent and the arbiter must grant it next. Eight postponed refreshes are the most that may be issued back to back. Holding the debt at that ceiling keeps the gap between two refreshes within eight average intervals, provided the arbiter honours the urgent request. A hold-off timer keeps the request low for the refresh cycle time after every accepted grant and after self-refresh exit. Grants are therefore spaced by at least that time.

A tick that arrives while the debt is already full sets a sticky overflow flag.

Top module: `ref_sched`

## Requirements
- R1: While rst_ni is low and just after it is released, req_o, urgent_o and overflow_o are 0 and debt_o is 0.
- R2: Every TREFI_CYC = ceil(7800 ns / clock period) clock edges after reset release (975 at 8 ns), debt_o rises by one, up to a ceiling of 8.
- R3: While debt_o is between 1 and 7 and no hold-off is active, req_o follows idle_i. req_o is never high while debt_o is 0.
- R4: When debt_o is 8 and no hold-off is active, req_o and urgent_o are both 1, whatever the value of idle_i. urgent_o is 0 whenever debt_o is below 8.
- R5: A grant_i sampled while req_o is high lowers debt_o by one on the next cycle. A grant_i sampled while req_o is low leaves debt_o unchanged.
- R6: After an accepted grant, req_o stays low for TRFC_CYC-1 cycles, with TRFC_CYC = ceil(60 ns / clock period), which is 8 at 8 ns. Consecutive grants are therefore at least TRFC_CYC edges apart.
- R7: A one-cycle sr_exit_i pulse holds req_o low for the next TRFC_CYC-1 cycles.
- R8: A tick that arrives while debt_o is 8 sets overflow_o. overflow_o stays 1 until reset, and debt_o stays at 8.
- R9: A tick and an accepted grant in the same cycle leave debt_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idle_i | input | 1 | Arbiter reports no pending traffic |
| grant_i | input | 1 | Arbiter issues the requested refresh this cycle |
| sr_exit_i | input | 1 | Pulse on self-refresh exit |
| req_o | output | 1 | Refresh request |
| urgent_o | output | 1 | Request must be granted next |
| overflow_o | output | 1 | Sticky: a tick arrived with full debt |
| debt_o | output | 4 | Number of owed refreshes, 0 to 8 |

## Verification
A wrong interval count first appears at debt_o, one edge early or late at the first tick, 975 cycles after reset. A corrupted debt value shows within one cycle: req_o may rise with no debt, urgent_o may be missing while idle_i is low, or the decrement after a grant may be wrong. A hold-off timer that is loaded badly lets req_o rise before the 7-cycle window has ended, which is visible on the first grant or self-refresh exit. A wrong saturation or overflow rule shows only after eight intervals without grants, so those cases take about 9000 cycles to reach.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;
  function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/ref_interval_tick.sv
module ref_interval_tick #(
  parameter int unsigned CYC = 975
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [W-1:0] LAST = W'(CYC - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/ref_debt_ctr.sv
module ref_debt_ctr #(
  parameter int unsigned MAX_DEBT = 8,
  parameter int unsigned DW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          take_i,
  output logic [DW-1:0] debt_o,
  output logic          full_o,
  output logic          ovf_o
);
  localparam logic [DW-1:0] FULL = DW'(MAX_DEBT);

  logic [DW-1:0] debt_q;
  logic          ovf_q;

  assign full_o = (debt_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      debt_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      unique case ({tick_i, take_i})
        2'b10:   if (!full_o) debt_q <= debt_q + 1'b1;
        2'b01:   debt_q <= debt_q - 1'b1;
        default: debt_q <= debt_q;  // idle, or tick and take cancel
      endcase
      if (tick_i && !take_i && full_o) ovf_q <= 1'b1;
    end
  end

  assign debt_o = debt_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/ref_holdoff.sv
module ref_holdoff #(
  parameter int unsigned CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  generate
    if (CYC > 1) begin : g_timer
      localparam int unsigned W = $clog2(CYC);
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          cnt_q <= '0;
        else if (load_i)      cnt_q <= W'(CYC - 1);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
      assign busy_o = (cnt_q != '0);
    end else begin : g_none
      assign busy_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ref_sched.sv
module ref_sched
  import ref_sched_pkg::*;
#(
  parameter int unsigned CLK_PS   = 8000,
  parameter int unsigned TREFI_NS = 7800,
  parameter int unsigned TRFC_NS  = 60,
  parameter int unsigned MAX_DEBT = 8,
  localparam int unsigned DW        = $clog2(MAX_DEBT + 1),
  localparam int unsigned TREFI_CYC = cdiv(TREFI_NS * 1000, CLK_PS),
  localparam int unsigned TRFC_CYC  = cdiv(TRFC_NS * 1000, CLK_PS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idle_i,
  input  logic          grant_i,
  input  logic          sr_exit_i,
  output logic          req_o,
  output logic          urgent_o,
  output logic          overflow_o,
  output logic [DW-1:0] debt_o
);
  logic tick, full, busy, take;

  ref_interval_tick #(.CYC(TREFI_CYC)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  ref_debt_ctr #(.MAX_DEBT(MAX_DEBT), .DW(DW)) u_debt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .take_i(take),
    .debt_o(debt_o), .full_o(full), .ovf_o(overflow_o)
  );

  ref_holdoff #(.CYC(TRFC_CYC)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(take | sr_exit_i), .busy_o(busy)
  );

  assign req_o    = !busy && (debt_o != '0) && (idle_i || full);
  assign urgent_o = req_o && full;
  assign take     = grant_i && req_o;
endmodule

// File: rtl/ref_sched_chk.sv
module ref_sched_chk #(
  parameter int unsigned MAX_DEBT = 8,
  parameter int unsigned DW       = 4,
  parameter int unsigned TRFC_CYC = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          idle_i,
  input logic          grant_i,
  input logic          sr_exit_i,
  input logic          req_o,
  input logic          urgent_o,
  input logic          overflow_o,
  input logic [DW-1:0] debt_o
);
  logic [15:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          gap_q <= 16'hFFFF;
    else if ((grant_i && req_o) || sr_exit_i) gap_q <= '0;
    else if (gap_q != 16'hFFFF)           gap_q <= gap_q + 1'b1;
  end

  // R6 and R7: the request stays low inside the hold-off window
  a_r6_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (gap_q >= 16'(TRFC_CYC - 1)));

  a_r3_idle_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !idle_i) |-> urgent_o);

  a_r3_no_req_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (debt_o == '0) |-> !req_o);

  a_r4_urgent_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_o |-> (debt_o == DW'(MAX_DEBT)));

  a_r5_grant_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && req_o) |=> (debt_o <= $past(debt_o)));

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r2_debt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debt_o <= DW'(MAX_DEBT));
endmodule

bind ref_sched ref_sched_chk #(.MAX_DEBT(MAX_DEBT), .DW(DW), .TRFC_CYC(TRFC_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(idle_i), .grant_i(grant_i),
  .sr_exit_i(sr_exit_i), .req_o(req_o), .urgent_o(urgent_o),
  .overflow_o(overflow_o), .debt_o(debt_o)
);

// File: tb/sim_ref_sched.sv
module sim_ref_sched;
  localparam int TREFI = (7800 * 1000 + 8000 - 1) / 8000;  // 975
  localparam int TRFC  = (60 * 1000 + 8000 - 1) / 8000;    // 8

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic idle_i = 1'b0, grant_i = 1'b0, sr_exit_i = 1'b0;
  logic req_o, urgent_o, overflow_o;
  logic [3:0] debt_o;
  int n_cmp = 0, n_bad = 0;

  always #4 clk_i = ~clk_i;

  ref_sched u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(idle_i), .grant_i(grant_i),
    .sr_exit_i(sr_exit_i), .req_o(req_o), .urgent_o(urgent_o),
    .overflow_o(overflow_o), .debt_o(debt_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; idle_i = 0; grant_i = 0; sr_exit_i = 0;
    edges(2);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk_i); rst_ni = 1'b0; #1;
    chk("R1 req in reset", req_o, 0);
    chk("R1 debt in reset", debt_o, 0);
    do_reset();
    chk("R1 req after release", req_o, 0);
    chk("R1 urgent after release", urgent_o, 0);
    chk("R1 overflow after release", overflow_o, 0);
  endtask

  task automatic t_tick_grant();
    do_reset();
    edges(TREFI - 1);
    chk("R2 debt before first tick", debt_o, 0);
    edges(1);
    chk("R2 debt after first tick", debt_o, 1);
    chk("R3 no req while busy arbiter", req_o, 0);
    idle_i = 1; #1;
    chk("R3 req when idle", req_o, 1);
    chk("R4 no urgent below full", urgent_o, 0);
    grant_i = 1; edges(1); grant_i = 0;
    chk("R5 debt after grant", debt_o, 0);
    chk("R3 no req at zero debt", req_o, 0);
  endtask

  task automatic t_ignored_grant();
    do_reset();
    edges(2 * TREFI);
    chk("R2 debt after two ticks", debt_o, 2);
    grant_i = 1; edges(3); grant_i = 0;
    chk("R5 grant without req ignored", debt_o, 2);
  endtask

  task automatic t_spacing();
    do_reset();
    edges(2 * TREFI);
    idle_i = 1; #1;
    chk("R6 req before grant", req_o, 1);
    grant_i = 1; edges(1); grant_i = 0;
    for (int i = 0; i < TRFC - 1; i++) begin
      chk("R6 req low in hold-off", req_o, 0);
      edges(1);
    end
    chk("R6 req back after hold-off", req_o, 1);
    chk("R6 debt", debt_o, 1);
  endtask

  task automatic t_sr_exit();
    do_reset();
    edges(TREFI);
    idle_i = 1;
    sr_exit_i = 1; edges(1); sr_exit_i = 0;
    for (int i = 0; i < TRFC - 1; i++) begin
      chk("R7 req low after self-refresh exit", req_o, 0);
      edges(1);
    end
    chk("R7 req after exit window", req_o, 1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    edges(2 * TREFI);
    idle_i = 1;
    edges(TREFI - 1);
    chk("R9 debt before tick", debt_o, 2);
    grant_i = 1; edges(1); grant_i = 0;
    chk("R9 tick plus grant keeps debt", debt_o, 2);
  endtask

  task automatic t_urgent();
    do_reset();
    edges(8 * TREFI);
    chk("R2 debt saturates at 8", debt_o, 8);
    chk("R4 req while not idle", req_o, 1);
    chk("R4 urgent at full", urgent_o, 1);
    chk("R8 no overflow yet", overflow_o, 0);
    edges(TREFI);
    chk("R8 overflow set", overflow_o, 1);
    chk("R8 debt held at 8", debt_o, 8);
    grant_i = 1; edges(1); grant_i = 0;
    chk("R5 urgent grant decrements", debt_o, 7);
    chk("R8 overflow sticky", overflow_o, 1);
    chk("R4 urgent drops below full", urgent_o, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_tick_grant();
    t_ignored_grant();
    t_spacing();
    t_sr_exit();
    t_same_cycle();
    t_urgent();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule